// File: doc/BRIEF.md
# Halfword-select signed multiply-accumulate-long unit

This unit decodes and executes one instruction: a signed 16 x 16 multiply whose 32-bit product is sign-extended and added to a 64-bit accumulator held in two 32-bit registers. Each factor is taken, under control of its own instruction bit, from either the lower or the upper half of its 32-bit source register. A mode input picks which of two instruction formats is decoded: a 32-bit fixed-length word, or a compact form made of two halfwords packed into the same 32-bit input.

The surrounding pipeline supplies the raw instruction, a flag that says the condition check passed, and the four register values the instruction reads. The unit returns, one clock later, the high and low destination indices, the two result words, a write enable, a flag for illegal register choices, and a flag for an instruction that matches neither format. The register file, condition evaluation and hazard logic live outside.

Top module: `halfmul_acc64`

## Requirements
- R1: With `fmt` = 0 the word matches only when bits 31:28 differ from 4'b1111, bits 27:20 equal 8'b00010100, bit 7 is 1 and bit 4 is 0. The high destination index is in bits 19:16 and the low one in bits 15:12. The second-source index is in bits 11:8 and the first-source index in bits 3:0. The first-half select is bit 5 and the second-half select is bit 6.
- R2: With `fmt` = 1, `insn[31:16]` is the first halfword and `insn[15:0]` is the second. A match needs first-halfword bits 15:4 to equal 12'hFBC and second-halfword bits 7:6 to equal 2'b10. The first-source index is first-halfword bits 3:0. In the second halfword, bits 15:12 hold the low destination index, bits 11:8 the high destination index and bits 3:0 the second-source index. Bit 5 is the first-half select and bit 4 the second-half select.
- R3: A select bit of 0 takes bits 15:0 of its source as a signed 16-bit factor, and 1 takes bits 31:16. The unused half has no effect on the result.
- R4: `{res_hi, res_lo}` equals `{acc_hi_val, acc_lo_val}` plus the sign-extended signed product, modulo 2^64, with no overflow indication.
- R5: `res_hi` carries result bits 63:32 and `res_lo` carries bits 31:0. `dst_hi_idx` and `dst_lo_idx` are the decoded high and low destination indices.
- R6: `wr_en` is 1 only for a matching instruction presented with `cond_ok` = 1. A matching instruction presented with `cond_ok` = 0 gives `wr_en` = 0 and `no_match` = 0.
- R7: A non-matching instruction gives `no_match` = 1, `wr_en` = 0 and `unpred` = 0.
- R8: For a matching instruction, `unpred` is 1 when any of the four indices equals 15 or the two destination indices are equal. Results and `wr_en` are still produced as for a legal instruction.
- R9: Every output reflects the inputs sampled at the previous rising clock edge, for every operand value. An asynchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 1 | 0: 32-bit format, 1: two-halfword format |
| insn | input | 32 | Raw instruction |
| cond_ok | input | 1 | Condition check passed |
| first_val | input | 32 | Value of the first-source register |
| second_val | input | 32 | Value of the second-source register |
| acc_hi_val | input | 32 | Value of the high destination register (accumulator bits 63:32) |
| acc_lo_val | input | 32 | Value of the low destination register (accumulator bits 31:0) |
| dst_hi_idx | output | 4 | High destination index |
| dst_lo_idx | output | 4 | Low destination index |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| wr_en | output | 1 | Write back both result words |
| unpred | output | 1 | Illegal register choice |
| no_match | output | 1 | Instruction matches neither format |

## Verification
The bench sweeps both formats and all four half selections against factor values that include -32768, 32767, -1, 0 and 1. Each source also carries a decoy value in its unused half, so a design that reads the wrong half, or treats the factors as unsigned, yields a wrong sum. Accumulators placed just below 2^63 and 2^64 expose a carry that is lost, or a product that is zero-extended instead of sign-extended. Single-bit corruptions of each fixed pattern field, an index of 15 in each field, equal destinations and a failed condition show whether a design accepts a bad word, misses the illegal case, or writes back when it should not.

// File: rtl/halfmul_acc64.sv
module halfmul_acc64 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt,
  input  logic [31:0] insn,
  input  logic        cond_ok,
  input  logic [31:0] first_val,
  input  logic [31:0] second_val,
  input  logic [31:0] acc_hi_val,
  input  logic [31:0] acc_lo_val,
  output logic [3:0]  dst_hi_idx,
  output logic [3:0]  dst_lo_idx,
  output logic [31:0] res_hi,
  output logic [31:0] res_lo,
  output logic        wr_en,
  output logic        unpred,
  output logic        no_match
);
  localparam logic [3:0]  COND_NEVER = 4'b1111;
  localparam logic [7:0]  WIDE_OPC   = 8'b0001_0100;
  localparam logic [11:0] CMP_OPC    = 12'hFBC;
  localparam logic [1:0]  CMP_TAG    = 2'b10;
  localparam logic [3:0]  IDX_BAD    = 4'd15;

  logic [15:0] hw_a, hw_b;
  assign hw_a = insn[31:16];
  assign hw_b = insn[15:0];

  logic wide_hit, cmp_hit, hit;
  assign wide_hit = (insn[31:28] != COND_NEVER) && (insn[27:20] == WIDE_OPC)
                 && insn[7] && !insn[4];
  assign cmp_hit  = (hw_a[15:4] == CMP_OPC) && (hw_b[7:6] == CMP_TAG);
  assign hit      = fmt ? cmp_hit : wide_hit;

  logic [3:0] i_hi, i_lo, i_first, i_second;
  logic       sel_first, sel_second;
  assign i_hi       = fmt ? hw_b[11:8]  : insn[19:16];
  assign i_lo       = fmt ? hw_b[15:12] : insn[15:12];
  assign i_first    = fmt ? hw_a[3:0]   : insn[3:0];
  assign i_second   = fmt ? hw_b[3:0]   : insn[11:8];
  assign sel_first  = fmt ? hw_b[5]     : insn[5];
  assign sel_second = fmt ? hw_b[4]     : insn[6];

  logic signed [15:0] fa, fb;
  logic signed [31:0] prod;
  logic        [63:0] sum;
  assign fa   = sel_first  ? first_val[31:16]  : first_val[15:0];
  assign fb   = sel_second ? second_val[31:16] : second_val[15:0];
  assign prod = fa * fb;
  assign sum  = {acc_hi_val, acc_lo_val} + {{32{prod[31]}}, prod};

  logic bad;
  assign bad = (i_hi == IDX_BAD) || (i_lo == IDX_BAD) || (i_first == IDX_BAD)
            || (i_second == IDX_BAD) || (i_hi == i_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_hi_idx <= '0;
      dst_lo_idx <= '0;
      res_hi     <= '0;
      res_lo     <= '0;
      wr_en      <= 1'b0;
      unpred     <= 1'b0;
      no_match   <= 1'b0;
    end else begin
      dst_hi_idx <= i_hi;
      dst_lo_idx <= i_lo;
      res_hi     <= sum[63:32];
      res_lo     <= sum[31:0];
      wr_en      <= hit && cond_ok;
      unpred     <= hit && bad;
      no_match   <= !hit;
    end
  end
endmodule

// File: rtl/halfmul_acc64_chk.sv
module halfmul_acc64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cond_ok,
  input logic [31:0] acc_hi_val,
  input logic [31:0] acc_lo_val,
  input logic [3:0]  dst_hi_idx,
  input logic [3:0]  dst_lo_idx,
  input logic [31:0] res_hi,
  input logic [31:0] res_lo,
  input logic        wr_en,
  input logic        unpred,
  input logic        no_match
);
  logic [63:0] acc_q, delta;
  always_ff @(posedge clk) acc_q <= {acc_hi_val, acc_lo_val};
  assign delta = {res_hi, res_lo} - acc_q;

  AST_WE_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cond_ok)); // R6
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (!wr_en && !unpred)); // R7
  AST_LEGAL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unpred) |-> (dst_hi_idx != dst_lo_idx && dst_hi_idx != 4'd15
                            && dst_lo_idx != 4'd15)); // R8
  AST_DELTA_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_en) |-> (delta[63:31] == '0 || delta[63:31] == '1)); // R4
endmodule

bind halfmul_acc64 halfmul_acc64_chk i_chk (.*);

// File: tb/test_halfmul_acc64.sv
module test_halfmul_acc64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt = 1'b0;
  logic [31:0] insn = '0;
  logic        cond_ok = 1'b0;
  logic [31:0] first_val = '0, second_val = '0, acc_hi_val = '0, acc_lo_val = '0;
  logic [3:0]  dst_hi_idx, dst_lo_idx;
  logic [31:0] res_hi, res_lo;
  logic        wr_en, unpred, no_match;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  halfmul_acc64 i_halfmul_acc64 (.*);

  function automatic logic [31:0] enc_w(logic [3:0] cnd, logic [3:0] h, logic [3:0] l,
      logic [3:0] s2, logic ms, logic ns, logic [3:0] s1);
    return {cnd, 8'b00010100, h, l, s2, 1'b1, ms, ns, 1'b0, s1};
  endfunction

  function automatic logic [31:0] enc_c(logic [3:0] s1, logic [3:0] l, logic [3:0] h,
      logic ns, logic ms, logic [3:0] s2);
    return {12'hFBC, s1, l, h, 2'b10, ns, ms, s2};
  endfunction

  task automatic run(input logic md, input logic [31:0] w, input logic co,
      input logic [31:0] v1, input logic [31:0] v2, input logic [63:0] acc,
      input logic [15:0] qa, input logic [15:0] qb,
      input logic e_hit, input logic e_unp, input logic [3:0] e_h, input logic [3:0] e_l,
      input string tag);
    logic [63:0] e_sum;
    logic [31:0] p;
    fmt = md; insn = w; cond_ok = co; first_val = v1; second_val = v2;
    acc_hi_val = acc[63:32]; acc_lo_val = acc[31:0];
    p = 32'($signed(qa) * $signed(qb));
    e_sum = acc + {{32{p[31]}}, p};
    @(posedge clk); @(negedge clk);
    checks++;
    if (wr_en !== (e_hit && co) || no_match !== !e_hit || unpred !== (e_hit && e_unp)) begin
      failures++;
      $display("FAIL %s flags we/um/nm got %b%b%b exp %b%b%b", tag, wr_en, unpred, no_match,
               e_hit && co, e_hit && e_unp, !e_hit);
    end else if (e_hit && ({res_hi, res_lo} !== e_sum || dst_hi_idx !== e_h || dst_lo_idx !== e_l)) begin
      failures++;
      $display("FAIL %s result got %h/%h,%h exp %h/%h,%h", tag, {res_hi, res_lo}, dst_hi_idx,
               dst_lo_idx, e_sum, e_h, e_l);
    end
  endtask

  logic [15:0] pats [6] = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001, 16'h1234};
  logic [63:0] accs [4] = '{64'h0, 64'h7FFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF8,
                            64'h8000_0000_0000_0005};

  initial begin
    #100000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] v1, v2;
    repeat (2) @(negedge clk);
    checks++;
    if ({dst_hi_idx, dst_lo_idx, res_hi, res_lo, wr_en, unpred, no_match} !== '0) begin
      failures++;
      $display("FAIL R9 reset outputs got %h exp 0", {res_hi, res_lo});
    end
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R9: sweep formats, selects, extremes and wrap accumulators
    for (int md = 0; md < 2; md++)
      for (int n = 0; n < 2; n++)
        for (int m = 0; m < 2; m++)
          for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
              for (int k = 0; k < 4; k++) begin
                logic [15:0] ga, gb;
                ga = ~pats[i] ^ 16'h5A5A;
                gb = ~pats[j] ^ 16'hC3C3;
                v1 = n[0] ? {pats[i], ga} : {ga, pats[i]};
                v2 = m[0] ? {pats[j], gb} : {gb, pats[j]};
                w = md[0] ? enc_c(4'd1, 4'd8, 4'd9, n[0], m[0], 4'd2)
                          : enc_w(4'd0, 4'd9, 4'd8, 4'd2, m[0], n[0], 4'd1);
                run(md[0], w, 1'b1, v1, v2, accs[k], pats[i], pats[j], 1, 0, 4'd9, 4'd8,
                    "R1 R2 R3 R4 sweep");
              end

    v1 = 32'h0003_FFFE; v2 = 32'h7FFF_8000;
    // R6: failed condition, no write and no mismatch
    run(0, enc_w(4'hE, 9, 8, 2, 0, 0, 1), 0, v1, v2, 64'd1, 16'hFFFE, 16'h8000, 1, 0, 9, 8, "R6 wide cond");
    run(1, enc_c(1, 8, 9, 1, 1, 2), 0, v1, v2, 64'd1, 16'h0003, 16'h7FFF, 1, 0, 9, 8, "R6 compact cond");

    // R7: corrupted fixed fields
    run(0, enc_w(4'hF, 9, 8, 2, 0, 0, 1), 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 cond 1111");
    run(0, enc_w(4'h0, 9, 8, 2, 0, 0, 1) ^ 32'h0010_0000, 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 opcode bit");
    run(0, enc_w(4'h0, 9, 8, 2, 0, 0, 1) ^ 32'h0000_0080, 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 bit7");
    run(0, enc_w(4'h0, 9, 8, 2, 0, 0, 1) ^ 32'h0000_0010, 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 bit4");
    run(1, enc_c(1, 8, 9, 0, 0, 2) ^ 32'h0010_0000, 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 compact opc");
    run(1, enc_c(1, 8, 9, 0, 0, 2) ^ 32'h0000_0040, 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 compact tag");
    run(1, enc_w(4'h0, 9, 8, 2, 0, 0, 1), 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 wide word in compact mode");
    run(0, enc_c(1, 8, 9, 0, 0, 2), 1, v1, v2, 0, 0, 0, 0, 0, 0, 0, "R7 compact word in wide mode");

    // R8: index 15 in each field and equal destinations
    for (int md = 0; md < 2; md++)
      for (int f = 0; f < 5; f++) begin
        logic [3:0] h, l, s1, s2;
        h = 9; l = 8; s1 = 1; s2 = 2;
        case (f)
          0: h = 15;
          1: l = 15;
          2: s1 = 15;
          3: s2 = 15;
          default: h = 8;
        endcase
        w = md[0] ? enc_c(s1, l, h, 0, 0, s2) : enc_w(4'h0, h, l, s2, 0, 0, s1);
        run(md[0], w, 1, v1, v2, 64'h10, 16'hFFFE, 16'h8000, 1, 1, h, l, "R8 unpredictable");
      end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule